// File: doc/BRIEF.md
# Serial Port Register and Interrupt Block

This block is the software-facing side of a serial port. A processor reaches it over a small valid/ready register bus with word-aligned offsets. It keeps the configuration that the transmitter, receiver and baud generator need, and presents that configuration to them as plain output ports. It also reports the live state of the FIFOs and modem lines, and collects eleven interrupt sources into a single interrupt line.

Data flows through the data register. A write to it hands a byte to the transmit FIFO through a one-cycle push strobe. A read returns the byte at the head of the receive FIFO, together with its error flags, and sends a one-cycle pop strobe. Error flags seen on data reads collect in a sticky receive-status word, which any write to that offset clears.

Interrupt sources come from the datapath as one-cycle event pulses. Each pulse sets a raw status bit, which stays set until software writes a 1 to the matching bit of the clear register. The mask selects which raw bits reach the masked status word and the interrupt output.

Top module: `uart_regblock`

## Requirements
- R1: Configuration registers sit at these byte offsets and read back the written value truncated to their width: IrDA count 0x20 (8 bits), integer divisor 0x24 (16), fractional divisor 0x28 (6), line control 0x2C (8), control 0x30 (16), FIFO level 0x34 (6), mask 0x38 (11), DMA control 0x48 (3). Each one drives its output port directly.
- R2: The reserved offsets 0x08–0x14 and 0x1C, any offset from 0x4C upward, and any address whose two low bits are not zero all read as zero, and writes to them change nothing. Writes to the read-only offsets 0x18, 0x3C and 0x40 are also ignored.
- R3: A write to offset 0x00 produces `tx_push` high for exactly the next cycle, with `tx_byte` equal to write-data bits 7:0.
- R4: A read of offset 0x00 returns `rx_byte` in bits 7:0 and framing, parity, break and overrun in bits 8, 9, 10 and 11. It drives `rx_pop` high for the next cycle.
- R5: Offset 0x04 reads the error flags ORed together over all data reads since the last clear, with framing at bit 0, parity at 1, break at 2 and overrun at 3. Any write to 0x04 clears them.
- R6: Offset 0x18 reads CTS at bit 0, DSR at 1, DCD at 2, busy at 3, receive-empty at 4, transmit-full at 5, receive-full at 6, transmit-empty at 7 and ring at 8, all sampled when the read is accepted.
- R7: A pulse on `irq_evt[i]` sets raw bit i, readable at 0x3C, and the bit stays set until it is cleared. The bit order is ring 0, CTS 1, DCD 2, DSR 3, receive 4, transmit 5, receive timeout 6, framing 7, parity 8, break 9, overrun 10.
- R8: Writing to 0x44 clears every raw bit written as 1 and leaves the bits written as 0 unchanged. An event pulse in the same cycle wins over the clear. Offset 0x44 reads as zero.
- R9: Offset 0x40 reads raw AND mask. `irq_out` is the OR of the masked bits and follows any change of raw or mask one cycle later.
- R10: After reset every register is zero, except control, which is 0x0300 (both transmit and receive enabled). `irq_out`, `rsp_valid`, `tx_push` and `rx_pop` are low.
- R11: `bus_ready` stays high. Every accepted read produces `rsp_valid` for exactly the following cycle, and `rsp_valid` is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request |
| bus_ready | output | 1 | Access accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| rx_byte | input | 8 | Byte at receive FIFO head |
| rx_err_flags | input | 4 | Head errors: framing, parity, break, overrun (bits 0..3) |
| rx_pop | output | 1 | Advance receive FIFO |
| tx_push | output | 1 | Push byte to transmit FIFO |
| tx_byte | output | 8 | Byte to transmit |
| line_cts | input | 1 | Clear-to-send line |
| line_dsr | input | 1 | Data-set-ready line |
| line_dcd | input | 1 | Carrier-detect line |
| line_ri | input | 1 | Ring line |
| tx_busy | input | 1 | Transmitter shifting |
| rxq_empty | input | 1 | Receive FIFO empty |
| txq_full | input | 1 | Transmit FIFO full |
| rxq_full | input | 1 | Receive FIFO full |
| txq_empty | input | 1 | Transmit FIFO empty |
| irq_evt | input | 11 | Interrupt event pulses |
| irq_out | output | 1 | Combined interrupt |
| irda_cnt | output | 8 | IrDA low-power count |
| baud_int | output | 16 | Integer baud divisor |
| baud_frac | output | 6 | Fractional baud divisor |
| line_ctrl | output | 8 | Line control word |
| port_ctrl | output | 16 | Control word |
| fifo_lvl | output | 6 | FIFO trigger levels (tx 2:0, rx 5:3) |
| dma_ctrl | output | 3 | DMA control |

## Verification
The in-line properties watch the interrupt state on every cycle. A pulse always sets its raw bit, a clear with no competing event always drops the bits, raw status never moves without a cause, and the output rises only when a masked bit was pending. Every cycle they also check that each push, pop and read response traces back to an accepted access of the right kind, and that a status write empties the error word. The scenarios alone show the things that depend on data values: the field positions in the data, flag and status words, the OR-accumulation of errors over several reads, the width truncation of each register, and that writes to reserved, read-only and misaligned addresses leave the stored state untouched.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_IRQ = 11;
  localparam int ERR_W   = 4;

  // register indices (byte offset / 4); software depends on these
  localparam int IDX_DATA  = 0;
  localparam int IDX_RSTAT = 1;
  localparam int IDX_FLAG  = 6;
  localparam int IDX_IRDA  = 8;
  localparam int IDX_BAUDI = 9;
  localparam int IDX_BAUDF = 10;
  localparam int IDX_LINE  = 11;
  localparam int IDX_CTRL  = 12;
  localparam int IDX_LEVEL = 13;
  localparam int IDX_MASK  = 14;
  localparam int IDX_RAW   = 15;
  localparam int IDX_MSKD  = 16;
  localparam int IDX_CLR   = 17;
  localparam int IDX_DMA   = 18;

  typedef struct packed {
    logic ring, txe, rxf, txf, rxe, busy, dcd, dsr, cts;
  } flag_t;
endpackage

// File: rtl/uart_rb_bus.sv
module uart_rb_bus #(
  parameter int ADDR_W = 7,
  localparam int IDX_W = ADDR_W - 2,
  localparam int NREG  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ready,
  output logic              rd_acc,
  output logic              aligned,
  output logic [IDX_W-1:0]  idx,
  output logic [NREG-1:0]   wr_sel,
  output logic              rsp_valid
);
  logic acc;

  assign bus_ready = 1'b1;
  assign acc       = bus_valid && bus_ready;
  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign idx       = bus_addr[ADDR_W-1:2];
  assign rd_acc    = acc && !bus_write;

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign wr_sel[g] = acc && bus_write && aligned && (idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= rd_acc;
  end

  // R11
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> rsp_valid);
  // R11
  rsp_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(bus_valid && !bus_write));
endmodule

// File: rtl/uart_rb_field.sv
module uart_rb_field #(
  parameter int         W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST;
    else if (we) q <= d;
  end
endmodule

// File: rtl/uart_rb_cfg.sv
module uart_rb_cfg
  import uart_rb_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int IRDA_W  = 8,
  parameter int BAUDI_W = 16,
  parameter int BAUDF_W = 6,
  parameter int LINE_W  = 8,
  parameter int CTRL_W  = 16,
  parameter int LEVEL_W = 6,
  parameter int DMA_W   = 3,
  parameter logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(16'h0300)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NREG-1:0]    wr_sel,
  input  logic [DATA_W-1:0]  wdata,
  output logic [IRDA_W-1:0]  irda_cnt,
  output logic [BAUDI_W-1:0] baud_int,
  output logic [BAUDF_W-1:0] baud_frac,
  output logic [LINE_W-1:0]  line_ctrl,
  output logic [CTRL_W-1:0]  port_ctrl,
  output logic [LEVEL_W-1:0] fifo_lvl,
  output logic [NUM_IRQ-1:0] irq_mask,
  output logic [DMA_W-1:0]   dma_ctrl
);
  uart_rb_field #(.W(IRDA_W)) u_irda (.clk, .rst,
    .we(wr_sel[IDX_IRDA]), .d(wdata[IRDA_W-1:0]), .q(irda_cnt));
  uart_rb_field #(.W(BAUDI_W)) u_baudi (.clk, .rst,
    .we(wr_sel[IDX_BAUDI]), .d(wdata[BAUDI_W-1:0]), .q(baud_int));
  uart_rb_field #(.W(BAUDF_W)) u_baudf (.clk, .rst,
    .we(wr_sel[IDX_BAUDF]), .d(wdata[BAUDF_W-1:0]), .q(baud_frac));
  uart_rb_field #(.W(LINE_W)) u_line (.clk, .rst,
    .we(wr_sel[IDX_LINE]), .d(wdata[LINE_W-1:0]), .q(line_ctrl));
  uart_rb_field #(.W(CTRL_W), .RST(CTRL_RST)) u_ctrl (.clk, .rst,
    .we(wr_sel[IDX_CTRL]), .d(wdata[CTRL_W-1:0]), .q(port_ctrl));
  uart_rb_field #(.W(LEVEL_W)) u_level (.clk, .rst,
    .we(wr_sel[IDX_LEVEL]), .d(wdata[LEVEL_W-1:0]), .q(fifo_lvl));
  uart_rb_field #(.W(NUM_IRQ)) u_mask (.clk, .rst,
    .we(wr_sel[IDX_MASK]), .d(wdata[NUM_IRQ-1:0]), .q(irq_mask));
  uart_rb_field #(.W(DMA_W)) u_dma (.clk, .rst,
    .we(wr_sel[IDX_DMA]), .d(wdata[DMA_W-1:0]), .q(dma_ctrl));
endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
  import uart_rb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] evt,
  input  logic               clr_we,
  input  logic [NUM_IRQ-1:0] clr_bits,
  input  logic [NUM_IRQ-1:0] mask,
  output logic [NUM_IRQ-1:0] raw,
  output logic [NUM_IRQ-1:0] mskd,
  output logic               irq_o
);
  logic [NUM_IRQ-1:0] kill;

  assign kill = clr_we ? clr_bits : '0;
  assign mskd = raw & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw   <= '0;
      irq_o <= 1'b0;
    end else begin
      raw   <= (raw & ~kill) | evt;
      irq_o <= |mskd;
    end
  end

  // R7
  evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((raw & $past(evt)) == $past(evt)));
  // R8
  clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((raw & $past(clr_bits & ~evt)) == '0));
  // R7
  raw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_we && evt == '0) |=> $stable(raw));
  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past((raw & mask) != '0));
endmodule

// File: rtl/uart_regblock.sv
module uart_regblock
  import uart_rb_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int BYTE_W  = 8,
  parameter int IRDA_W  = 8,
  parameter int BAUDI_W = 16,
  parameter int BAUDF_W = 6,
  parameter int LINE_W  = 8,
  parameter int CTRL_W  = 16,
  parameter int LEVEL_W = 6,
  parameter int DMA_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_valid,
  output logic               bus_ready,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic [BYTE_W-1:0]  rx_byte,
  input  logic [ERR_W-1:0]   rx_err_flags,
  output logic               rx_pop,
  output logic               tx_push,
  output logic [BYTE_W-1:0]  tx_byte,
  input  logic               line_cts,
  input  logic               line_dsr,
  input  logic               line_dcd,
  input  logic               line_ri,
  input  logic               tx_busy,
  input  logic               rxq_empty,
  input  logic               txq_full,
  input  logic               rxq_full,
  input  logic               txq_empty,
  input  logic [NUM_IRQ-1:0] irq_evt,
  output logic               irq_out,
  output logic [IRDA_W-1:0]  irda_cnt,
  output logic [BAUDI_W-1:0] baud_int,
  output logic [BAUDF_W-1:0] baud_frac,
  output logic [LINE_W-1:0]  line_ctrl,
  output logic [CTRL_W-1:0]  port_ctrl,
  output logic [LEVEL_W-1:0] fifo_lvl,
  output logic [DMA_W-1:0]   dma_ctrl
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int NREG  = 1 << IDX_W;

  logic               rd_acc, aligned;
  logic [IDX_W-1:0]   idx;
  logic [NREG-1:0]    wr_sel;
  logic [NUM_IRQ-1:0] irq_mask, raw, mskd;
  logic [ERR_W-1:0]   rsr;
  logic [DATA_W-1:0]  rd_word;
  logic               data_rd;
  flag_t              flags;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_W];

  uart_rb_bus #(.ADDR_W(ADDR_W)) u_bus (
    .clk, .rst, .bus_valid, .bus_write, .bus_addr, .bus_ready,
    .rd_acc, .aligned, .idx, .wr_sel, .rsp_valid);

  uart_rb_cfg #(.NREG(NREG), .IRDA_W(IRDA_W), .BAUDI_W(BAUDI_W),
    .BAUDF_W(BAUDF_W), .LINE_W(LINE_W), .CTRL_W(CTRL_W),
    .LEVEL_W(LEVEL_W), .DMA_W(DMA_W)) u_cfg (
    .clk, .rst, .wr_sel, .wdata(bus_wdata), .irda_cnt, .baud_int,
    .baud_frac, .line_ctrl, .port_ctrl, .fifo_lvl, .irq_mask, .dma_ctrl);

  uart_rb_irq u_irq (
    .clk, .rst, .evt(irq_evt), .clr_we(wr_sel[IDX_CLR]),
    .clr_bits(bus_wdata[NUM_IRQ-1:0]), .mask(irq_mask),
    .raw, .mskd, .irq_o(irq_out));

  assign flags = '{ring: line_ri, txe: txq_empty, rxf: rxq_full,
                   txf: txq_full, rxe: rxq_empty, busy: tx_busy,
                   dcd: line_dcd, dsr: line_dsr, cts: line_cts};

  assign data_rd = rd_acc && aligned && (idx == IDX_W'(IDX_DATA));

  always_comb begin
    rd_word = '0;
    if (aligned) begin
      case (int'(idx))
        IDX_DATA:  rd_word = DATA_W'({rx_err_flags, rx_byte});
        IDX_RSTAT: rd_word = DATA_W'(rsr);
        IDX_FLAG:  rd_word = DATA_W'(flags);
        IDX_IRDA:  rd_word = DATA_W'(irda_cnt);
        IDX_BAUDI: rd_word = DATA_W'(baud_int);
        IDX_BAUDF: rd_word = DATA_W'(baud_frac);
        IDX_LINE:  rd_word = DATA_W'(line_ctrl);
        IDX_CTRL:  rd_word = DATA_W'(port_ctrl);
        IDX_LEVEL: rd_word = DATA_W'(fifo_lvl);
        IDX_MASK:  rd_word = DATA_W'(irq_mask);
        IDX_RAW:   rd_word = DATA_W'(raw);
        IDX_MSKD:  rd_word = DATA_W'(mskd);
        IDX_DMA:   rd_word = DATA_W'(dma_ctrl);
        default:   rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
      rx_pop    <= 1'b0;
      tx_push   <= 1'b0;
      tx_byte   <= '0;
      rsr       <= '0;
    end else begin
      rx_pop  <= data_rd;
      tx_push <= wr_sel[IDX_DATA];
      if (rd_acc) rsp_rdata <= rd_word;
      if (wr_sel[IDX_DATA]) tx_byte <= bus_wdata[BYTE_W-1:0];
      if (wr_sel[IDX_RSTAT]) rsr <= '0;
      else if (data_rd)      rsr <= rsr | rx_err_flags;
    end
  end

  // R3
  push_cause_chk: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> $past(bus_valid && bus_write && bus_addr == '0));
  // R4
  pop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(bus_valid && !bus_write && bus_addr == '0));
  // R5
  rsr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_sel[IDX_RSTAT] |=> (rsr == '0));
endmodule

// File: tb/sim_uart_regblock.sv
module sim_uart_regblock;
  logic        clk = 0, rst = 1;
  logic        bus_valid = 0, bus_write = 0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, rsp_valid, rx_pop, tx_push, irq_out;
  logic [31:0] rsp_rdata;
  logic [7:0]  rx_byte = '0, tx_byte, irda_cnt, line_ctrl;
  logic [3:0]  rx_err_flags = '0;
  logic        line_cts = 0, line_dsr = 0, line_dcd = 0, line_ri = 0;
  logic        tx_busy = 0, rxq_empty = 0, txq_full = 0, rxq_full = 0, txq_empty = 0;
  logic [10:0] irq_evt = '0;
  logic [15:0] baud_int, port_ctrl;
  logic [5:0]  baud_frac, fifo_lvl;
  logic [2:0]  dma_ctrl;

  int n_chk = 0, n_err = 0;
  logic last_rv, last_pop;
  bit done = 0;

  always #5 clk = ~clk;

  uart_regblock u0 (.*);

  typedef struct packed {
    logic       rsv;
    logic [6:0] a;
    logic [31:0] w;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{1'b0, 7'h20, 32'h0000_01A5, 32'h0000_00A5},
    '{1'b0, 7'h24, 32'hDEAD_BEEF, 32'h0000_BEEF},
    '{1'b0, 7'h28, 32'h0000_00FF, 32'h0000_003F},
    '{1'b0, 7'h2C, 32'h0000_01C3, 32'h0000_00C3},
    '{1'b0, 7'h30, 32'h1234_C381, 32'h0000_C381},
    '{1'b0, 7'h34, 32'h0000_00FF, 32'h0000_003F},
    '{1'b0, 7'h38, 32'h0000_F5A5, 32'h0000_05A5},
    '{1'b0, 7'h48, 32'h0000_00FF, 32'h0000_0007},
    '{1'b1, 7'h08, 32'hFFFF_FFFF, 32'h0000_0000},
    '{1'b1, 7'h1C, 32'hFFFF_FFFF, 32'h0000_0000},
    '{1'b1, 7'h4C, 32'hFFFF_FFFF, 32'h0000_0000},
    '{1'b1, 7'h25, 32'h0000_FFFF, 32'h0000_0000},
    '{1'b1, 7'h3C, 32'h0000_07FF, 32'h0000_0000},
    '{1'b1, 7'h40, 32'h0000_07FF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk); bus_valid = 0;
    d = rsp_rdata; last_rv = rsp_valid; last_pop = rx_pop;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk("R10", {31'b0, irq_out}, 0);
    chk("R10", {31'b0, rsp_valid}, 0);
    chk("R10", {16'b0, port_ctrl}, 32'h300);
    chk("R11", {31'b0, bus_ready}, 1);
    rd(7'h30, d); chk("R10", d, 32'h300);
    chk("R11", {31'b0, last_rv}, 1);
    @(negedge clk); chk("R11", {31'b0, rsp_valid}, 0);
    rd(7'h38, d); chk("R10", d, 0);

    // table of register write/readback vectors (R1, R2)
    for (int i = 0; i < 14; i++) begin
      wr(VECS[i].a, VECS[i].w);
      rd(VECS[i].a, d);
      chk(VECS[i].rsv ? "R2" : "R1", d, VECS[i].e);
    end
    chk("R1", {16'b0, baud_int}, 32'hBEEF);
    chk("R1", {16'b0, port_ctrl}, 32'hC381);
    chk("R1", {26'b0, fifo_lvl}, 32'h3F);
    chk("R1", {29'b0, dma_ctrl}, 32'h7);
    // R2 reserved and misaligned writes left divisor untouched
    wr(7'h14, 32'h0); wr(7'h27, 32'h0);
    rd(7'h24, d); chk("R2", d, 32'hBEEF);
    wr(7'h38, 32'h0);

    // R3 transmit push
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = 7'h00; bus_wdata = 32'h1C5;
    @(negedge clk); bus_valid = 0; bus_write = 0;
    chk("R3", {31'b0, tx_push}, 1);
    chk("R3", {24'b0, tx_byte}, 32'hC5);
    @(negedge clk); chk("R3", {31'b0, tx_push}, 0);

    // R4 receive read and R5 accumulation
    rx_byte = 8'h3C; rx_err_flags = 4'b0101;
    rd(7'h00, d); chk("R4", d, 32'h53C); chk("R4", {31'b0, last_pop}, 1);
    @(negedge clk); chk("R4", {31'b0, rx_pop}, 0);
    rx_byte = 8'h11; rx_err_flags = 4'b1000;
    rd(7'h00, d); chk("R4", d, 32'h811);
    rx_err_flags = 4'b0010;
    rd(7'h04, d); chk("R5", d, 32'hD);
    wr(7'h04, 32'h0);
    rd(7'h04, d); chk("R5", d, 0);

    // R6 flag mapping, two patterns
    line_cts = 1; line_dcd = 1; rxq_empty = 1; txq_empty = 1; line_ri = 1;
    rd(7'h18, d); chk("R6", d, 32'h195);
    line_cts = 0; line_dcd = 0; rxq_empty = 0; txq_empty = 0; line_ri = 0;
    line_dsr = 1; tx_busy = 1; txq_full = 1; rxq_full = 1;
    rd(7'h18, d); chk("R6", d, 32'h06A);

    // R7 raw set and hold
    @(negedge clk); irq_evt = 11'h410;
    @(negedge clk); irq_evt = '0;
    repeat (3) @(negedge clk);
    rd(7'h3C, d); chk("R7", d, 32'h410);
    chk("R9", {31'b0, irq_out}, 0);
    // R9 mask
    wr(7'h38, 32'h010);
    rd(7'h40, d); chk("R9", d, 32'h010);
    chk("R9", {31'b0, irq_out}, 1);
    // R8 write-one-to-clear
    wr(7'h44, 32'h400);
    rd(7'h3C, d); chk("R8", d, 32'h010);
    chk("R9", {31'b0, irq_out}, 1);
    rd(7'h44, d); chk("R8", d, 0);
    wr(7'h44, 32'h010);
    @(negedge clk);
    chk("R9", {31'b0, irq_out}, 0);
    rd(7'h3C, d); chk("R8", d, 0);
    // R8 event beats clear in same cycle
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = 7'h44;
    bus_wdata = 32'h040; irq_evt = 11'h040;
    @(negedge clk); bus_valid = 0; bus_write = 0; irq_evt = '0;
    rd(7'h3C, d); chk("R8", d, 32'h040);
    chk("R9", {31'b0, irq_out}, 0);

    finish_run();
  end
endmodule